// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This register block keeps the interrupt state of a multi-channel DMA engine. There are three groups: transmit channels, receive channels, and a single host-error condition. Each group keeps a raw status vector and an enable mask. A pulse on a per-channel event input sets a raw bit. The matching acknowledge input clears it. Software never writes a mask directly. It writes ones to a set address to turn bits on and ones to a clear address to turn them off. The masked status is the raw status ANDed with the mask, and software reads it separately from the raw view.

The block drives one combined interrupt line from all masked bits. Software acknowledges an interrupt by writing to an end-of-interrupt address. That write pulls the line low for one cycle. The line then comes back if any masked bit is still pending, so no event is lost. The bus is a plain single-cycle write port with a combinational read port. Reads have no side effects.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every raw bit and every mask bit is zero and `irq` is low.
- R2: An event pulse on a channel sets that channel's raw bit, and the new value is visible from the next cycle. An acknowledge pulse clears the bit. If the event and the acknowledge arrive in the same cycle, the bit ends up set. Raw status for a group is read at offset 0x0 of that group's window. The transmit window is at 0x00, the receive window at 0x10 and the host-error window at 0x20.
- R3: A write to offset 0x8 of a group's window turns on the mask bits where the write data is one. Bits where the data is zero keep their value. A cycle with no write to offset 0x8 or 0xC of a group leaves that group's mask unchanged.
- R4: A write to offset 0xC of a group's window turns off the mask bits where the write data is one. Writing 0xFFFFFFFF there disables every channel of that group at once.
- R5: A read at offset 0x8 or offset 0xC of a group's window returns that group's current mask.
- R6: A read at offset 0x4 of a group's window returns the raw status ANDed with the mask. Writes to offset 0x0 and offset 0x4 change neither the raw status nor the mask.
- R7: The host-error group implements only bit 1, for both raw status and mask. Every other bit of that group reads as zero whatever is written.
- R8: When there was no end-of-interrupt write in the previous cycle, `irq` equals the OR of all masked bits of all groups as they stood in the previous cycle.
- R9: Any write to address 0x30 is an end-of-interrupt. It forces `irq` low in the next cycle. After that, `irq` follows R8 again.
- R10: Reads return zero at address 0x30, at any address from 0x34 upward, and at any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (8) | Byte address for both read and write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| tx_evt | input | NUM_CH (8) | Per-channel transmit event pulses |
| tx_ack | input | NUM_CH (8) | Per-channel transmit acknowledge pulses |
| rx_evt | input | NUM_CH (8) | Per-channel receive event pulses |
| rx_ack | input | NUM_CH (8) | Per-channel receive acknowledge pulses |
| herr_evt | input | 1 | Host-error event pulse |
| herr_ack | input | 1 | Host-error acknowledge pulse |
| irq | output | 1 | Combined, registered interrupt line |

## Verification
A wrong raw bit or mask bit shows up on the bus the very next cycle. Reading that group's raw, masked or mask address returns a value that differs from a model built from the event, acknowledge and write history. It also shows up on `irq` one cycle later, once the masked OR changes. A missing end-of-interrupt gap or a stuck line shows up in the single cycle after the write to 0x30. The bench therefore compares the read data and `irq` against its model on every cycle and sweeps addresses across all windows. This catches a divergence at the first cycle in which it can be seen.

// File: rtl/irq_mask_pkg.sv
// Package: shared constants for the interrupt mask controller.
// Assumes a byte-addressed map of 16-byte windows, one per group, with
// four 32-bit registers in each window.
package irq_mask_pkg;
    localparam int GRP_TX   = 0;
    localparam int GRP_RX   = 1;
    localparam int GRP_HERR = 2;
    localparam int NUM_GRP  = 3;
    localparam int HERR_BIT = 1;
    localparam int SEL_LSB  = 2;
    localparam int GRP_LSB  = 4;
    localparam int MAP_BITS = 6;
    localparam logic [1:0] EOI_WIN = 2'd3;

    typedef enum logic [1:0] {
        SEL_RAW  = 2'd0,
        SEL_MSKD = 2'd1,
        SEL_SET  = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
// Module: decodes a bus address into per-group set/clear write strobes,
// an end-of-interrupt strobe and read selectors.
// Assumes the address is byte aligned and the upper bits beyond the map are zero.
module irq_bus_decode
    import irq_mask_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_GRP-1:0] set_stb,
    output logic [NUM_GRP-1:0] clr_stb,
    output logic              eoi_stb,
    output logic              rd_hit,
    output logic [1:0]        rd_grp,
    output reg_sel_e          rd_sel
);
    logic       in_map;
    logic [1:0] win;

    // Purpose: check alignment and range, and split the address fields.
    always_comb begin
        in_map = ((bus_addr >> MAP_BITS) == '0) && (bus_addr[SEL_LSB-1:0] == 2'b00);
        win    = bus_addr[GRP_LSB+1:GRP_LSB];
        rd_grp = win;
        rd_sel = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
        rd_hit = in_map && (win != EOI_WIN);
    end

    // Purpose: produce one-hot write strobes per group.
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            set_stb[g] = bus_wr && rd_hit && (win == 2'(g)) && (rd_sel == SEL_SET);
            clr_stb[g] = bus_wr && rd_hit && (win == 2'(g)) && (rd_sel == SEL_CLR);
        end
        eoi_stb = bus_wr && in_map && (win == EOI_WIN) && (rd_sel == SEL_RAW);
    end
endmodule

// File: rtl/irq_status_group.sv
// Module: raw status and enable mask for one interrupt group.
// Assumes the events and acknowledges are single-cycle pulses. Only the
// bits set in IMPL exist. The others are held at zero.
module irq_status_group #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] ack,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] masked
);
    logic [DATA_W-1:0] raw_q, mask_q;

    // Purpose: raw status; an event wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= ((raw_q & ~ack) | evt) & IMPL;
    end

    // Purpose: enable mask, changed only through set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (set_stb) mask_q <= (mask_q | wdata) & IMPL;
        else if (clr_stb) mask_q <= mask_q & ~wdata;
    end

    assign raw    = raw_q;
    assign mask   = mask_q;
    assign masked = raw_q & mask_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(evt & IMPL)) == $past(evt & IMPL))); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(ack & ~evt)) == '0)); // R2
    AST_SET_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(mask)); // R3
    AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask & $past(wdata)) == '0)); // R4
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw | mask) & ~IMPL) == '0)); // R7
endmodule

// File: rtl/irq_line_gen.sv
// Module: registered combined interrupt line with an end-of-interrupt gap.
// Assumes any_pend is the OR of all masked bits from the groups.
module irq_line_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi_stb,
    output logic irq
);
    logic irq_q;

    // Purpose: follow pending state, but drop for one cycle after an EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_pend && !eoi_stb;
    end

    assign irq = irq_q;

    AST_EOI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |=> !irq); // R9
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_stb |=> (irq == $past(any_pend))); // R8
endmodule

// File: rtl/irq_mask_ctrl.sv
// Module: top level of the interrupt mask set/clear controller.
// Holds transmit, receive and host-error groups, a read mux and the
// combined interrupt line. Assumes NUM_CH <= DATA_W and ADDR_W >= 6.
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] tx_ack,
    input  logic [NUM_CH-1:0] rx_evt,
    input  logic [NUM_CH-1:0] rx_ack,
    input  logic              herr_evt,
    input  logic              herr_ack,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CH_IMPL   = {DATA_W{1'b1}} >> (DATA_W - NUM_CH);
    localparam logic [DATA_W-1:0] HERR_IMPL = DATA_W'(1) << HERR_BIT;

    logic [NUM_GRP-1:0] set_stb, clr_stb;
    logic               eoi_stb, rd_hit;
    logic [1:0]         rd_grp;
    reg_sel_e           rd_sel;
    logic [DATA_W-1:0]  evt_v [NUM_GRP];
    logic [DATA_W-1:0]  ack_v [NUM_GRP];
    logic [DATA_W-1:0]  raw_v [NUM_GRP];
    logic [DATA_W-1:0]  mask_v [NUM_GRP];
    logic [DATA_W-1:0]  mskd_v [NUM_GRP];
    logic               any_pend;

    irq_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .eoi_stb (eoi_stb),
        .rd_hit  (rd_hit),
        .rd_grp  (rd_grp),
        .rd_sel  (rd_sel)
    );

    // Purpose: widen the event and acknowledge inputs into group-wide vectors.
    always_comb begin
        evt_v[GRP_TX]   = DATA_W'(tx_evt);
        ack_v[GRP_TX]   = DATA_W'(tx_ack);
        evt_v[GRP_RX]   = DATA_W'(rx_evt);
        ack_v[GRP_RX]   = DATA_W'(rx_ack);
        evt_v[GRP_HERR] = DATA_W'(herr_evt) << HERR_BIT;
        ack_v[GRP_HERR] = DATA_W'(herr_ack) << HERR_BIT;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [DATA_W-1:0] G_IMPL = (g == GRP_HERR) ? HERR_IMPL : CH_IMPL;
        irq_status_group #(.DATA_W(DATA_W), .IMPL(G_IMPL)) i_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_v[g]),
            .ack    (ack_v[g]),
            .set_stb(set_stb[g]),
            .clr_stb(clr_stb[g]),
            .wdata  (bus_wdata),
            .raw    (raw_v[g]),
            .mask   (mask_v[g]),
            .masked (mskd_v[g])
        );
    end

    // Purpose: OR every masked bit of every group into one pending flag.
    always_comb begin
        any_pend = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) any_pend = any_pend | (|mskd_v[g]);
    end

    // Purpose: read mux; set and clear addresses both return the mask.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (rd_sel)
                SEL_RAW:  bus_rdata = raw_v[rd_grp];
                SEL_MSKD: bus_rdata = mskd_v[rd_grp];
                SEL_SET,
                SEL_CLR:  bus_rdata = mask_v[rd_grp];
                default:  bus_rdata = '0;
            endcase
        end
    end

    irq_line_gen i_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_pend(any_pend),
        .eoi_stb (eoi_stb),
        .irq     (irq)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && (raw_v[GRP_TX] == '0) && (mask_v[GRP_RX] == '0))); // R1
    AST_EOI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(8'h30)) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_evt, tx_ack, rx_evt, rx_ack;
    logic        herr_evt, herr_ack;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] m_raw  [3];
    logic [31:0] m_mask [3];
    logic        m_irq;
    bit          m_last_eoi;

    always #5 clk = ~clk;

    irq_mask_ctrl i_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_evt(tx_evt), .tx_ack(tx_ack), .rx_evt(rx_evt), .rx_ack(rx_ack),
        .herr_evt(herr_evt), .herr_ack(herr_ack), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] impl_of(input int g);
        return (g == 2) ? 32'h0000_0002 : 32'h0000_00FF;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int g;
        if (a >= 8'h40 || a[1:0] != 2'b00) return 32'h0;
        g = a / 16;
        if (g == 3) return 32'h0;
        case (a[3:2])
            2'd0:    return m_raw[g];
            2'd1:    return m_raw[g] & m_mask[g];
            default: return m_mask[g];
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        if (!rst_n) return "R1";
        if (a >= 8'h30 || a[1:0] != 2'b00) return "R10";
        if (a[5:4] == 2'd2) return "R7";
        case (a[3:2])
            2'd0:    return "R2";
            2'd1:    return "R6";
            default: return "R5";
        endcase
    endfunction

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] te, input logic [7:0] ta,
                       input logic [7:0] re, input logic [7:0] ra,
                       input logic he, input logic ha, input string tag);
        logic [31:0] ev [3];
        logic [31:0] ak [3];
        logic        pend;
        logic        eoi;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        tx_evt = te; tx_ack = ta; rx_evt = re; rx_ack = ra;
        herr_evt = he; herr_ack = ha;
        #1;
        check(bus_rdata, model_read(a), (tag != "") ? tag : read_tag(a), "read data");
        check({31'b0, irq}, {31'b0, m_irq}, !rst_n ? "R1" : (m_last_eoi ? "R9" : "R8"), "irq");
        if (!rst_n) begin
            for (int g = 0; g < 3; g++) begin m_raw[g] = '0; m_mask[g] = '0; end
            m_irq = 1'b0; m_last_eoi = 0;
        end else begin
            ev[0] = {24'b0, te}; ak[0] = {24'b0, ta};
            ev[1] = {24'b0, re}; ak[1] = {24'b0, ra};
            ev[2] = {30'b0, he, 1'b0}; ak[2] = {30'b0, ha, 1'b0};
            eoi  = w && (a == 8'h30);
            pend = 1'b0;
            for (int g = 0; g < 3; g++) pend = pend | (|(m_raw[g] & m_mask[g]));
            m_irq = pend && !eoi;
            m_last_eoi = eoi;
            for (int g = 0; g < 3; g++) begin
                m_raw[g] = ((m_raw[g] & ~ak[g]) | ev[g]) & impl_of(g);
                if (w && a == 8'(16 * g + 8))  m_mask[g] = (m_mask[g] | d) & impl_of(g);
                if (w && a == 8'(16 * g + 12)) m_mask[g] = m_mask[g] & ~d;
            end
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc(1'b0, a, 32'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, "");
    endtask

    initial begin
        for (int g = 0; g < 3; g++) begin m_raw[g] = '0; m_mask[g] = '0; end
        m_irq = 1'b0; m_last_eoi = 0;
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = '0;
        tx_evt = '0; tx_ack = '0; rx_evt = '0; rx_ack = '0; herr_evt = 0; herr_ack = 0;
        repeat (3) @(posedge clk);
        // R1: reset state seen on every window while reset is held
        for (int a = 0; a < 64; a += 4) rd(8'(a), "R1");
        rst_n = 1'b1;
        rd(8'h00, "R1");
        rd(8'h08, "R1");
        // R2: events set raw status
        cyc(1'b0, 8'h00, 0, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
        rd(8'h00, "R2");
        // R3: set ones, zeros keep value
        wr(8'h08, 32'h0000_0001);
        rd(8'h08, "R3");
        wr(8'h08, 32'h0000_0000);
        rd(8'h0C, "R3");
        // R6: masked view and ignored writes to raw and masked
        rd(8'h04, "R6");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, "R6");
        rd(8'h04, "R6");
        // R2: event and acknowledge in the same cycle, event wins
        cyc(1'b0, 8'h00, 0, 8'h01, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
        rd(8'h00, "R2");
        // R9: end-of-interrupt gap, then the line returns
        wr(8'h30, 32'h0);
        rd(8'h04, "R9");
        rd(8'h04, "R9");
        // R4: clear all channels at once
        wr(8'h08, 32'h0000_00FF);
        rd(8'h0C, "R4");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, "R4");
        rd(8'h04, "R4");
        // receive group: acknowledge clears, mask works independently
        cyc(1'b0, 8'h10, 0, 8'h00, 8'h00, 8'hA0, 8'h00, 1'b0, 1'b0, "R2");
        wr(8'h18, 32'h0000_0080);
        cyc(1'b0, 8'h10, 0, 8'h00, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0, "R2");
        rd(8'h14, "R6");
        // R7: host-error group keeps only bit 1
        cyc(1'b0, 8'h20, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R7");
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, "R7");
        rd(8'h24, "R7");
        rd(8'h20, "R7");
        // R10: end-of-interrupt, unmapped and unaligned reads are zero
        rd(8'h30, "R10");
        rd(8'h3C, "R10");
        rd(8'h48, "R10");
        rd(8'h09, "R10");
        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 17) * 4);
            if ($urandom_range(0, 15) == 0) a = 8'($urandom_range(0, 255));
            cyc(($urandom_range(0, 2) == 0), a, $urandom(),
                8'($urandom() & $urandom()), 8'($urandom() & $urandom()),
                8'($urandom() & $urandom()), 8'($urandom() & $urandom()),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule